// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column-address sequence that a synchronous DRAM walks through during a read or write burst. A packed mode word, loaded while the block is idle, sets four things: the burst length (1, 2, 4, 8 or a whole page), the ordering within the burst (wrapping sequential or XOR interleaved), the CAS latency, and a write override that limits write commands to one location. The decoded CAS latency is brought out for the rest of the controller to use.

A command strobe carries a read/write flag and a start column. From the next clock on, the block presents one column address per cycle with a valid flag. A last flag marks the final beat. A whole-page burst steps through all 512 columns and wraps. It stops only when it is terminated or replaced by a new command. A mode word with a reserved or illegal encoding is refused: the stored mode is kept and an error flag is raised.

Top module: `sdram_colseq`

## Requirements
- R1: The length field, mode bits [2:0], selects the beats per burst: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a whole page. After the final beat of a fixed-length burst, col_valid goes low unless a new command arrives.
- R2: With mode bit 3 at 0, the order is sequential. Beat i goes to the aligned block base plus ((start mod L) + i) mod L. For example, length 4 from start 2 gives 2,3,0,1, and length 8 from start 5 gives 5,6,7,0,1,2,3,4.
- R3: With mode bit 3 at 1, the order is interleaved. Beat i goes to the start column with its low log2(L) bits XORed with i, and the upper bits are held.
- R4: A whole-page burst emits start, start+1, and so on, modulo 512. It never raises col_last and runs until it is terminated or replaced.
- R5: When mode bit 9 is set, a write command produces exactly one beat (the start column, with col_last high). Reads still use the programmed length.
- R6: Mode bits [6:4] hold the CAS latency: 001, 010 and 011 give a cas_lat of 1, 2 and 3.
- R7: A load is refused if its word has any of these: a reserved length code (100, 101, 110), the page length combined with interleaved order, a latency code outside 001 to 011, or nonzero bits [11:10] or [8:7]. A refused load sets mode_err and keeps the previous mode. A valid load clears mode_err.
- R8: A mode load presented while a burst is active (col_valid high) has no effect on the mode or on mode_err.
- R9: After reset, no burst is active, mode_err is 0, and the mode is length 1, sequential, latency 2, with no write override.
- R10: A command strobe in cycle k makes col_valid high in cycle k+1 with col_out equal to the start column. The beat index then advances by one each cycle.
- R11: A command that arrives during a burst ends that burst. In the next cycle, the new burst's first beat appears.
- R12: A terminate seen at a clock edge ends any burst, including a page burst, so col_valid is low after that edge. If terminate and a command arrive together, the command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load strobe for the mode word |
| mode_word | input | 12 | Packed mode word |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_col | input | 9 | Start column of the burst |
| term | input | 1 | Ends the active burst |
| col_out | output | 9 | Column address of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cas_lat | output | 2 | Decoded CAS latency (1 to 3) |
| mode_err | output | 1 | The last accepted load was refused as illegal |

## Verification
The hardest situations to reach from the ports are a mode load and a command landing in the middle of a running burst. Refusing a load is invisible unless the next burst's length and the latency output are both inspected afterwards. The bench first samples a few beats of a burst. On the following edge it drives the competing load, command or terminate, then keeps comparing beats from the exact cycle where the effect must show. A page burst started at column 510 runs past 520 beats, which covers the wrap through zero and the absence of a last flag.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    localparam int COL_W  = 9;
    localparam int MODE_W = 12;

    localparam logic [2:0] LEN_PAGE = 3'b111;

    typedef struct packed {
        logic [2:0] len_code;
        logic       interleave;
        logic [1:0] cas;
        logic       wr_single;
    } mode_t;

    localparam mode_t MODE_RESET = '{len_code: 3'b000, interleave: 1'b0,
                                     cas: 2'd2, wr_single: 1'b0};

    function automatic logic len_legal(input logic [2:0] code);
        return (code <= 3'b011) || (code == LEN_PAGE);
    endfunction

    function automatic logic word_legal(input logic [MODE_W-1:0] w);
        logic lat_ok;
        lat_ok = (w[6:4] == 3'b001) || (w[6:4] == 3'b010) || (w[6:4] == 3'b011);
        return len_legal(w[2:0]) && !((w[2:0] == LEN_PAGE) && w[3]) && lat_ok
            && (w[11:10] == 2'b00) && (w[8:7] == 2'b00);
    endfunction

    function automatic mode_t decode_word(input logic [MODE_W-1:0] w);
        mode_t m;
        m.len_code   = w[2:0];
        m.interleave = w[3];
        m.cas        = w[5:4];
        m.wr_single  = w[9];
        return m;
    endfunction

endpackage

// File: rtl/colseq_mode_reg.sv
module colseq_mode_reg
    import colseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              busy,
    input  logic [MODE_W-1:0] word,
    output mode_t             mode_q,
    output logic              err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
            err_q  <= 1'b0;
        end else if (load && !busy) begin
            if (word_legal(word)) begin
                mode_q <= decode_word(word);
                err_q  <= 1'b0;
            end else begin
                err_q  <= 1'b1;
            end
        end
    end

    a_r8_load_blocked: assert property (@(posedge clk) disable iff (rst)
        (load && busy) |=> ($stable(mode_q) && $stable(err_q)));

    a_r7_bad_word_kept: assert property (@(posedge clk) disable iff (rst)
        (load && !busy && !word_legal(word)) |=> (err_q && $stable(mode_q)));

    a_r6_cas_legal: assert property (@(posedge clk) disable iff (rst)
        mode_q.cas != 2'd0);

endmodule

// File: rtl/colseq_beat_ctrl.sv
module colseq_beat_ctrl
    import colseq_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [CW-1:0] cmd_col,
    input  logic          term,
    input  logic [2:0]    len_code,
    input  logic          interleave,
    input  logic          wr_single,
    output logic          active,
    output logic [CW-1:0] beat,
    output logic [CW-1:0] start,
    output logic [CW-1:0] mask,
    output logic          ilv,
    output logic          page,
    output logic          last
);

    logic          single;
    logic [CW-1:0] new_mask;
    logic          new_page;

    assign single   = cmd_write && wr_single;
    assign new_page = !single && (len_code == LEN_PAGE);

    always_comb begin
        if (single)
            new_mask = '0;
        else if (len_code == LEN_PAGE)
            new_mask = '1;
        else
            new_mask = CW'((1 << len_code[1:0]) - 1);
    end

    assign last = active && !page && (beat == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            beat   <= '0;
            start  <= '0;
            mask   <= '0;
            ilv    <= 1'b0;
            page   <= 1'b0;
        end else if (cmd_valid) begin
            active <= 1'b1;
            beat   <= '0;
            start  <= cmd_col;
            mask   <= new_mask;
            ilv    <= interleave;
            page   <= new_page;
        end else if (active) begin
            if (term || last)
                active <= 1'b0;
            else
                beat <= beat + 1'b1;
        end
    end

    a_r12_term_stops: assert property (@(posedge clk) disable iff (rst)
        (term && !cmd_valid) |=> !active);

    a_r1_end_after_last: assert property (@(posedge clk) disable iff (rst)
        (last && !cmd_valid) |=> !active);

    a_r10_beat_advance: assert property (@(posedge clk) disable iff (rst)
        (active && !last && !term && !cmd_valid) |=> (active && beat == $past(beat) + 1'b1));

endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen #(
    parameter int CW = colseq_pkg::COL_W
) (
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] beat,
    input  logic [CW-1:0] mask,
    input  logic          ilv,
    output logic [CW-1:0] col
);

    logic [CW-1:0] seq_col;
    logic [CW-1:0] xor_col;

    assign seq_col = (start & ~mask) | ((start + beat) & mask);
    assign xor_col = start ^ (beat & mask);
    assign col     = ilv ? xor_col : seq_col;

endmodule

// File: rtl/sdram_colseq.sv
module sdram_colseq
    import colseq_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [CW-1:0]     cmd_col,
    input  logic              term,
    output logic [CW-1:0]     col_out,
    output logic              col_valid,
    output logic              col_last,
    output logic [1:0]        cas_lat,
    output logic              mode_err
);

    mode_t         mode_q;
    logic          active;
    logic [CW-1:0] beat;
    logic [CW-1:0] start;
    logic [CW-1:0] mask;
    logic          ilv;
    logic          page;
    logic          last;

    colseq_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .load   (mode_load),
        .busy   (active),
        .word   (mode_word),
        .mode_q (mode_q),
        .err_q  (mode_err)
    );

    colseq_beat_ctrl #(.CW(CW)) u_beat (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .cmd_col    (cmd_col),
        .term       (term),
        .len_code   (mode_q.len_code),
        .interleave (mode_q.interleave),
        .wr_single  (mode_q.wr_single),
        .active     (active),
        .beat       (beat),
        .start      (start),
        .mask       (mask),
        .ilv        (ilv),
        .page       (page),
        .last       (last)
    );

    colseq_addr_gen #(.CW(CW)) u_addr (
        .start (start),
        .beat  (beat),
        .mask  (mask),
        .ilv   (ilv),
        .col   (col_out)
    );

    assign col_valid = active;
    assign col_last  = last;
    assign cas_lat   = mode_q.cas;

    a_r10_first_beat: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (col_valid && col_out == $past(cmd_col)));

    a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write && mode_q.wr_single) |=> col_last);

    a_r4_page_step: assert property (@(posedge clk) disable iff (rst)
        (col_valid && page && !term && !cmd_valid)
        |=> (col_valid && !col_last && col_out == $past(col_out) + 1'b1));

endmodule

// File: tb/sdram_colseq_bench.sv
`timescale 1ns/1ps
module sdram_colseq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_load;
    logic [11:0] mode_word;
    logic        cmd_valid;
    logic        cmd_write;
    logic [8:0]  cmd_col;
    logic        term;
    logic [8:0]  col_out;
    logic        col_valid;
    logic        col_last;
    logic [1:0]  cas_lat;
    logic        mode_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [2:0] m_len;
    logic       m_ilv;
    logic [1:0] m_cas;
    logic       m_wb;
    logic       m_err;

    always #5 clk = ~clk;

    sdram_colseq u_sdram_colseq (
        .clk       (clk),
        .rst       (rst),
        .mode_load (mode_load),
        .mode_word (mode_word),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_col   (cmd_col),
        .term      (term),
        .col_out   (col_out),
        .col_valid (col_valid),
        .col_last  (col_last),
        .cas_lat   (cas_lat),
        .mode_err  (mode_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int blen(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_col(input int s, input int i, input int L, input bit x);
        int base;
        int off;
        if (L == 0) return (s + i) % 512;
        base = s - (s % L);
        off  = s % L;
        if (x) return base + (off ^ (i % L));
        return base + ((off + i) % L);
    endfunction

    function automatic bit ok_word(input logic [11:0] w);
        int lat;
        lat = int'(w[6:4]);
        return (w[2:0] <= 3'd3 || w[2:0] == 3'd7) && !(w[2:0] == 3'd7 && w[3])
            && lat >= 1 && lat <= 3 && w[11:10] == 2'b00 && w[8:7] == 2'b00;
    endfunction

    function automatic logic [11:0] mk(input logic [2:0] len, input logic bt,
                                       input logic [2:0] lat, input logic wb,
                                       input logic [1:0] rsv);
        return {rsv, wb, 2'b00, lat, bt, len};
    endfunction

    task automatic load(input logic [11:0] w);
        mode_load = 1'b1;
        mode_word = w;
        @(negedge clk);
        mode_load = 1'b0;
        if (ok_word(w)) begin
            m_len = w[2:0];
            m_ilv = w[3];
            m_cas = w[5:4];
            m_wb  = w[9];
            m_err = 1'b0;
        end else begin
            m_err = 1'b1;
        end
        chk(cas_lat == m_cas, "R6 cas_lat", int'(cas_lat), int'(m_cas));
        chk(mode_err == m_err, "R7 mode_err", int'(mode_err), int'(m_err));
    endtask

    task automatic issue(input bit wr, input int col);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_col   = 9'(col);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic beats(input int s, input int L, input bit x, input int first,
                         input int n, input string req);
        for (int i = first; i < first + n; i++) begin
            int  ec;
            bit  el;
            ec = exp_col(s, i, L, x);
            el = (L != 0) && (i == L - 1);
            chk(col_valid == 1'b1, req, int'(col_valid), 1);
            chk(int'(col_out) == ec, req, int'(col_out), ec);
            chk(col_last == el, req, int'(col_last), int'(el));
            if (i < first + n - 1) @(negedge clk);
        end
    endtask

    task automatic idle_chk(input string req);
        @(negedge clk);
        chk(col_valid == 1'b0, req, int'(col_valid), 0);
    endtask

    task automatic burst(input bit wr, input int s, input string req);
        int L;
        L = (wr && m_wb) ? 1 : blen(m_len);
        issue(wr, s);
        if (L == 0) begin
            beats(s, 0, m_ilv, 0, 16, req);
            term = 1'b1;
            @(negedge clk);
            term = 1'b0;
            chk(col_valid == 1'b0, "R12 term page", int'(col_valid), 0);
        end else begin
            beats(s, L, m_ilv, 0, L, req);
            idle_chk(req);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode_load = 1'b0; mode_word = '0; cmd_valid = 1'b0;
        cmd_write = 1'b0; cmd_col = '0; term = 1'b0;
        m_len = 3'd0; m_ilv = 1'b0; m_cas = 2'd2; m_wb = 1'b0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        chk(col_valid == 1'b0, "R9 valid", int'(col_valid), 0);
        chk(col_last == 1'b0, "R9 last", int'(col_last), 0);
        chk(cas_lat == 2'd2, "R9 cas", int'(cas_lat), 2);
        chk(mode_err == 1'b0, "R9 err", int'(mode_err), 0);
        burst(1'b0, 77, "R9 length 1 after reset");

        // R1 each fixed length
        for (int c = 0; c < 4; c++) begin
            load(mk(3'(c), 1'b0, 3'd2, 1'b0, 2'b00));
            burst(1'b0, 0, "R1 length");
        end

        // R2 sequential wrap
        load(mk(3'd2, 1'b0, 3'd2, 1'b0, 2'b00));
        burst(1'b0, 2, "R2 len4 start2");
        load(mk(3'd3, 1'b0, 3'd2, 1'b0, 2'b00));
        burst(1'b0, 5, "R2 len8 start5");
        burst(1'b1, 13, "R2 len8 start13");

        // R3 interleaved
        load(mk(3'd3, 1'b1, 3'd3, 1'b0, 2'b00));
        burst(1'b0, 5, "R3 len8 start5");
        load(mk(3'd2, 1'b1, 3'd1, 1'b0, 2'b00));
        burst(1'b0, 6, "R3 len4 start6");

        // R4 page burst across the wrap
        load(mk(3'd7, 1'b0, 3'd2, 1'b0, 2'b00));
        issue(1'b0, 510);
        beats(510, 0, 1'b0, 0, 520, "R4 page wrap");
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk(col_valid == 1'b0, "R4 page ends on term", int'(col_valid), 0);

        // R5 single-location writes
        load(mk(3'd3, 1'b0, 3'd3, 1'b1, 2'b00));
        burst(1'b1, 33, "R5 write single");
        burst(1'b0, 33, "R5 read full length");

        // R7 refused words keep the mode (len8, cas3)
        load(mk(3'd3, 1'b0, 3'd3, 1'b0, 2'b00));
        load(mk(3'd4, 1'b0, 3'd2, 1'b0, 2'b00));
        load(mk(3'd7, 1'b1, 3'd2, 1'b0, 2'b00));
        load(mk(3'd1, 1'b0, 3'd0, 1'b0, 2'b00));
        load(mk(3'd1, 1'b0, 3'd4, 1'b0, 2'b00));
        load(mk(3'd1, 1'b0, 3'd1, 1'b0, 2'b01));
        load(12'h0A1);
        chk(cas_lat == 2'd3, "R7 mode kept", int'(cas_lat), 3);
        burst(1'b0, 3, "R7 length kept");
        load(mk(3'd1, 1'b0, 3'd1, 1'b0, 2'b00));
        chk(mode_err == 1'b0, "R7 cleared", int'(mode_err), 0);

        // R8 load during burst is ignored
        load(mk(3'd3, 1'b0, 3'd2, 1'b0, 2'b00));
        issue(1'b0, 16);
        beats(16, 8, 1'b0, 0, 3, "R8 before load");
        mode_load = 1'b1;
        mode_word = mk(3'd1, 1'b0, 3'd3, 1'b0, 2'b00);
        @(negedge clk);
        mode_load = 1'b0;
        beats(16, 8, 1'b0, 3, 5, "R8 after load");
        idle_chk("R8 burst end");
        chk(cas_lat == 2'd2, "R8 cas unchanged", int'(cas_lat), 2);
        chk(mode_err == 1'b0, "R8 err unchanged", int'(mode_err), 0);
        burst(1'b0, 9, "R8 length unchanged");

        // R11 new command aborts
        issue(1'b0, 40);
        beats(40, 8, 1'b0, 0, 3, "R11 first");
        issue(1'b1, 100);
        beats(100, 8, 1'b0, 0, 8, "R11 replacement");
        idle_chk("R11 end");

        // R12 terminate, and terminate with command
        issue(1'b0, 60);
        beats(60, 8, 1'b0, 0, 2, "R12 before term");
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk(col_valid == 1'b0, "R12 term", int'(col_valid), 0);
        issue(1'b0, 60);
        beats(60, 8, 1'b0, 0, 2, "R12 before term+cmd");
        term = 1'b1; cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 9'd200;
        @(negedge clk);
        term = 1'b0; cmd_valid = 1'b0;
        beats(200, 8, 1'b0, 0, 8, "R12 command wins");
        idle_chk("R12 end");

        // random modes and bursts (R1 R2 R3 R4 R5)
        void'($urandom(32'd1234));
        for (int k = 0; k < 60; k++) begin
            logic [2:0] len;
            logic       bt;
            len = 3'($urandom % 5);
            if (len == 3'd4) len = 3'd7;
            bt = (len == 3'd7) ? 1'b0 : 1'($urandom % 2);
            load(mk(len, bt, 3'(1 + $urandom % 3), 1'($urandom % 2), 2'b00));
            burst(1'($urandom % 2), int'($urandom % 512), "R2 R3 random burst");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule